// File: doc/BRIEF.md
# Multi-Word Load/Store Micro-op Sequencer

This block sits between decode and issue in a core whose register file has two read ports and one write port. It takes one decoded instruction at a time and breaks it into a stream of single-word micro-operations that fit that register file. Load-multiple and store-multiple instructions become one micro-op per word. A base-register update adds one trailing micro-op. A single load or store becomes a pair when it moves a double word. A store whose offset comes from a register gets an address micro-op before its data micro-ops. A double-word register move becomes an even-then-odd pair. Every other instruction passes through as one micro-op.

Each micro-op carries an opcode, a register number, a word index, a byte offset equal to four times that index, first and last markers, and a forward marker. The forward marker flags the word whose loaded result dependent consumers may use. The output side uses a valid/ready handshake. The sequencer holds its current micro-op while ready is low. It takes the next instruction only after the last micro-op of the current one has been accepted.

Input class encoding on `in_cls`: 0 load-multiple, 1 store-multiple, 2 single load, 3 single store, 4 double-word move, 5 to 7 other. Micro-op encoding on `uop_op`: 0 load word, 1 store word, 2 base write, 3 address, 4 move, 5 pass.

Top module: `mw_uop_seq`

## Requirements
- R1: A load-multiple (class 0) or store-multiple (class 1) with count N emits N word micro-ops, op 0 (load) or op 1 (store). They carry word indices 0..N-1 in ascending order and register `in_rd`+index modulo 2^REG_W. A count of 0 is treated as 1, and a count above MAX_WORDS is clamped to MAX_WORDS.
- R2: When `in_upd` is set on classes 0 to 3, one extra base-write micro-op (op 2, register `in_base`, index 0) follows the last other micro-op. On classes 4 to 7, `in_upd` has no effect.
- R3: A single load (class 2) or single store (class 3) emits one word micro-op, register `in_rd`, index 0. With `in_dword` set it emits two, with indices 0 and 1 and registers `in_rd` and `in_rd`+1.
- R4: A single store with `in_regoff` set first emits an address micro-op (op 3, register `in_base`, index 0), and its data micro-ops follow. On all other classes, `in_regoff` has no effect.
- R5: A double-word move (class 4) emits two move micro-ops (op 4). The first uses register `in_rd` with bit 0 cleared and index 0. The second uses `in_rd` with bit 0 set and index 1.
- R6: Classes 5 to 7 emit exactly one pass micro-op (op 5, register `in_rd`, index 0).
- R7: `uop_fwd` is 1 only on the last load-word micro-op of a class 0 or class 2 instruction, and 0 on every other micro-op.
- R8: `uop_first` marks the first micro-op and `uop_last` the last micro-op of each instruction, and `uop_ofs` always equals `uop_idx` times 4.
- R9: While `uop_valid` is 1 and `uop_ready` is 0, every micro-op output holds its value into the next cycle.
- R10: `in_ready` equals not `busy`. `busy` rises in the cycle after an instruction is accepted and falls in the cycle after its last micro-op is accepted. `uop_valid` is 1 exactly while `busy` is 1.
- R11: After synchronous reset, `uop_valid` and `busy` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Sequencer can take an instruction |
| in_cls | input | 3 | Instruction class |
| in_rd | input | REG_W | First data register |
| in_base | input | REG_W | Base register |
| in_cnt | input | CNT_W | Register-list word count |
| in_upd | input | 1 | Base register update requested |
| in_regoff | input | 1 | Offset taken from a register |
| in_dword | input | 1 | Double-word single access |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Issue stage takes the micro-op |
| uop_op | output | 3 | Micro-op kind |
| uop_reg | output | REG_W | Register the micro-op writes or reads |
| uop_idx | output | IDX_W | Word index within the instruction |
| uop_ofs | output | IDX_W+2 | Byte offset of the word |
| uop_first | output | 1 | First micro-op of the instruction |
| uop_last | output | 1 | Last micro-op of the instruction |
| uop_fwd | output | 1 | Result of this word goes to dependent consumers |
| busy | output | 1 | An instruction is being sequenced |

## Verification
The bound checker checks several properties on every cycle: that a stalled micro-op stays unchanged, that the byte offset tracks the index, that the forward marker appears only on load words, that word indices climb by one between consecutive word micro-ops, and how busy and input readiness behave around acceptance and release. Only the bench's scenarios can show that each class produces the right number and order of micro-ops. Those scenarios also cover the correct registers under wrap-around, count clamping, and that the update and register-offset flags are ignored where they do not apply. The bench's reference model rebuilds each expected sequence from the requirements and compares it against the outputs cycle by cycle, with ready held high and with ready toggling.

// File: rtl/mw_seq_pkg.sv
package mw_seq_pkg;

  typedef enum logic [2:0] {
    CLS_LDM   = 3'd0,
    CLS_STM   = 3'd1,
    CLS_LD    = 3'd2,
    CLS_ST    = 3'd3,
    CLS_MOVD  = 3'd4,
    CLS_OTHER = 3'd5
  } cls_e;

  typedef enum logic [2:0] {
    OP_LDW  = 3'd0,
    OP_STW  = 3'd1,
    OP_BWB  = 3'd2,
    OP_ADDR = 3'd3,
    OP_MOVE = 3'd4,
    OP_PASS = 3'd5
  } op_e;

  function automatic cls_e to_cls(input logic [2:0] raw);
    case (raw)
      3'd0: to_cls = CLS_LDM;
      3'd1: to_cls = CLS_STM;
      3'd2: to_cls = CLS_LD;
      3'd3: to_cls = CLS_ST;
      3'd4: to_cls = CLS_MOVD;
      default: to_cls = CLS_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/mw_len_calc.sv
module mw_len_calc
  import mw_seq_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1),
  parameter int STEP_W    = $clog2(MAX_WORDS + 3)
) (
  input  cls_e              cls,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              upd,
  input  logic              regoff,
  input  logic              dword,
  output logic [STEP_W-1:0] words,
  output logic              pre,
  output logic [STEP_W-1:0] total
);

  logic wb;

  always_comb begin
    case (cls)
      CLS_LDM, CLS_STM: begin
        if (cnt == '0)
          words = STEP_W'(1);
        else if (int'(cnt) > MAX_WORDS)
          words = STEP_W'(MAX_WORDS);
        else
          words = STEP_W'(cnt);
      end
      CLS_LD, CLS_ST: words = dword ? STEP_W'(2) : STEP_W'(1);
      CLS_MOVD:       words = STEP_W'(2);
      default:        words = STEP_W'(1);
    endcase
    pre   = (cls == CLS_ST) && regoff;
    wb    = upd && ((cls == CLS_LDM) || (cls == CLS_STM) ||
                    (cls == CLS_LD)  || (cls == CLS_ST));
    total = words + STEP_W'(pre) + STEP_W'(wb);
  end

endmodule

// File: rtl/mw_step_gen.sv
module mw_step_gen
  import mw_seq_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int IDX_W  = 4,
  parameter int STEP_W = 5
) (
  input  cls_e              cls,
  input  logic [REG_W-1:0]  rd,
  input  logic [REG_W-1:0]  base,
  input  logic [STEP_W-1:0] words,
  input  logic              pre,
  input  logic [STEP_W-1:0] total,
  input  logic [STEP_W-1:0] step,
  output op_e               op,
  output logic [REG_W-1:0]  rg,
  output logic [IDX_W-1:0]  idx,
  output logic              first,
  output logic              last,
  output logic              fwd
);

  logic [STEP_W-1:0] wstep;

  always_comb begin
    wstep = step - STEP_W'(pre);
    op    = OP_PASS;
    rg    = rd;
    idx   = '0;
    fwd   = 1'b0;
    case (cls)
      CLS_LDM, CLS_LD: begin
        if (step < words) begin
          op  = OP_LDW;
          rg  = rd + REG_W'(step);
          idx = IDX_W'(step);
          fwd = (step == words - STEP_W'(1));
        end else begin
          op = OP_BWB;
          rg = base;
        end
      end
      CLS_STM, CLS_ST: begin
        if (pre && (step == '0)) begin
          op = OP_ADDR;
          rg = base;
        end else if (wstep < words) begin
          op  = OP_STW;
          rg  = rd + REG_W'(wstep);
          idx = IDX_W'(wstep);
        end else begin
          op = OP_BWB;
          rg = base;
        end
      end
      CLS_MOVD: begin
        op  = OP_MOVE;
        rg  = {rd[REG_W-1:1], step[0]};
        idx = IDX_W'(step);
      end
      default: begin
        op = OP_PASS;
        rg = rd;
      end
    endcase
    first = (step == '0);
    last  = (step == total - STEP_W'(1));
  end

endmodule

// File: rtl/mw_uop_seq.sv
module mw_uop_seq
  import mw_seq_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int MAX_WORDS = 16,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1),
  parameter int IDX_W     = $clog2(MAX_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_cls,
  input  logic [REG_W-1:0]   in_rd,
  input  logic [REG_W-1:0]   in_base,
  input  logic [CNT_W-1:0]   in_cnt,
  input  logic               in_upd,
  input  logic               in_regoff,
  input  logic               in_dword,
  output logic               uop_valid,
  input  logic               uop_ready,
  output logic [2:0]         uop_op,
  output logic [REG_W-1:0]   uop_reg,
  output logic [IDX_W-1:0]   uop_idx,
  output logic [IDX_W+1:0]   uop_ofs,
  output logic               uop_first,
  output logic               uop_last,
  output logic               uop_fwd,
  output logic               busy
);

  localparam int STEP_W = $clog2(MAX_WORDS + 3);

  cls_e              in_cls_e;
  logic [STEP_W-1:0] n_words, n_total;
  logic              n_pre;

  cls_e              cls_q;
  logic [REG_W-1:0]  rd_q, base_q;
  logic [STEP_W-1:0] words_q, total_q, step_q;
  logic              pre_q, busy_q;

  cls_e              g_cls;
  logic [REG_W-1:0]  g_rd, g_base;
  logic [STEP_W-1:0] g_words, g_total, g_step;
  logic              g_pre;

  op_e               g_op;
  logic [REG_W-1:0]  g_rg;
  logic [IDX_W-1:0]  g_idx;
  logic              g_first, g_last, g_fwd;

  logic take, fire;

  assign in_cls_e = to_cls(in_cls);
  assign take     = in_valid && !busy_q;
  assign fire     = busy_q && uop_ready;

  mw_len_calc #(
    .MAX_WORDS (MAX_WORDS),
    .CNT_W     (CNT_W),
    .STEP_W    (STEP_W)
  ) len_i (
    .cls    (in_cls_e),
    .cnt    (in_cnt),
    .upd    (in_upd),
    .regoff (in_regoff),
    .dword  (in_dword),
    .words  (n_words),
    .pre    (n_pre),
    .total  (n_total)
  );

  always_comb begin
    if (take) begin
      g_cls   = in_cls_e;
      g_rd    = in_rd;
      g_base  = in_base;
      g_words = n_words;
      g_pre   = n_pre;
      g_total = n_total;
      g_step  = '0;
    end else begin
      g_cls   = cls_q;
      g_rd    = rd_q;
      g_base  = base_q;
      g_words = words_q;
      g_pre   = pre_q;
      g_total = total_q;
      g_step  = step_q + STEP_W'(1);
    end
  end

  mw_step_gen #(
    .REG_W  (REG_W),
    .IDX_W  (IDX_W),
    .STEP_W (STEP_W)
  ) gen_i (
    .cls   (g_cls),
    .rd    (g_rd),
    .base  (g_base),
    .words (g_words),
    .pre   (g_pre),
    .total (g_total),
    .step  (g_step),
    .op    (g_op),
    .rg    (g_rg),
    .idx   (g_idx),
    .first (g_first),
    .last  (g_last),
    .fwd   (g_fwd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cls_q     <= CLS_OTHER;
      rd_q      <= '0;
      base_q    <= '0;
      words_q   <= '0;
      pre_q     <= 1'b0;
      total_q   <= '0;
      step_q    <= '0;
      uop_op    <= 3'd0;
      uop_reg   <= '0;
      uop_idx   <= '0;
      uop_ofs   <= '0;
      uop_first <= 1'b0;
      uop_last  <= 1'b0;
      uop_fwd   <= 1'b0;
    end else if (take || (fire && !uop_last)) begin
      busy_q    <= 1'b1;
      cls_q     <= g_cls;
      rd_q      <= g_rd;
      base_q    <= g_base;
      words_q   <= g_words;
      pre_q     <= g_pre;
      total_q   <= g_total;
      step_q    <= g_step;
      uop_op    <= g_op;
      uop_reg   <= g_rg;
      uop_idx   <= g_idx;
      uop_ofs   <= {g_idx, 2'b00};
      uop_first <= g_first;
      uop_last  <= g_last;
      uop_fwd   <= g_fwd;
    end else if (fire) begin
      busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign uop_valid = busy_q;
  assign in_ready  = !busy_q;

endmodule

// File: rtl/mw_uop_seq_chk.sv
module mw_uop_seq_chk #(
  parameter int REG_W     = 5,
  parameter int MAX_WORDS = 16,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1),
  parameter int IDX_W     = $clog2(MAX_WORDS)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_cls,
  input logic [REG_W-1:0] in_rd,
  input logic [REG_W-1:0] in_base,
  input logic [CNT_W-1:0] in_cnt,
  input logic             in_upd,
  input logic             in_regoff,
  input logic             in_dword,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [2:0]       uop_op,
  input logic [REG_W-1:0] uop_reg,
  input logic [IDX_W-1:0] uop_idx,
  input logic [IDX_W+1:0] uop_ofs,
  input logic             uop_first,
  input logic             uop_last,
  input logic             uop_fwd,
  input logic             busy
);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) &&
      $stable(uop_reg) && $stable(uop_idx) && $stable(uop_first) &&
      $stable(uop_last) && $stable(uop_fwd)));

  a_r8_offset: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> (uop_ofs == {uop_idx, 2'b00}));

  a_r8_first_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (uop_valid && uop_first));

  a_r7_fwd_on_load: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_fwd) |-> (uop_op == 3'd0));

  a_r1_ascending: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_ready && !uop_last && (uop_op <= 3'd1)) |=>
      ((uop_op != $past(uop_op)) || (uop_idx == $past(uop_idx) + 1'b1)));

  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_ready && uop_last) |=> (!busy && in_ready && !uop_valid));

  a_r10_blocked: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

endmodule

bind mw_uop_seq mw_uop_seq_chk #(
  .REG_W     (REG_W),
  .MAX_WORDS (MAX_WORDS),
  .CNT_W     (CNT_W),
  .IDX_W     (IDX_W)
) chk_i (.*);

// File: tb/mw_uop_seq_tb_top.sv
module mw_uop_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 5;
  localparam int MAXW       = 16;
  localparam int CNT_W      = $clog2(MAXW + 1);
  localparam int IDX_W      = $clog2(MAXW);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2:0]       in_cls = '0;
  logic [REG_W-1:0] in_rd = '0;
  logic [REG_W-1:0] in_base = '0;
  logic [CNT_W-1:0] in_cnt = '0;
  logic             in_upd = 1'b0, in_regoff = 1'b0, in_dword = 1'b0;
  logic             uop_valid;
  logic             uop_ready = 1'b1;
  logic [2:0]       uop_op;
  logic [REG_W-1:0] uop_reg;
  logic [IDX_W-1:0] uop_idx;
  logic [IDX_W+1:0] uop_ofs;
  logic             uop_first, uop_last, uop_fwd, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_uop_seq #(.REG_W(REG_W), .MAX_WORDS(MAXW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_rd(in_rd), .in_base(in_base), .in_cnt(in_cnt),
    .in_upd(in_upd), .in_regoff(in_regoff), .in_dword(in_dword),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
    .uop_reg(uop_reg), .uop_idx(uop_idx), .uop_ofs(uop_ofs),
    .uop_first(uop_first), .uop_last(uop_last), .uop_fwd(uop_fwd),
    .busy(busy));

  typedef struct {
    int    op;
    int    rg;
    int    idx;
    bit    first;
    bit    last;
    bit    fwd;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   rdy_mode = 0;
  bit   done = 0;
  bit   prev_stall = 0;
  logic [15:0] lfsr = 16'hACE1;
  int   p_op, p_rg, p_idx, p_fl;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic void push(input int op, input int rg, input int idx,
                               input bit fwd, input string tag);
    exp_t e;
    e.op = op; e.rg = rg % 32; e.idx = idx;
    e.first = 0; e.last = 0; e.fwd = fwd; e.tag = tag;
    q.push_back(e);
  endfunction

  // Expected micro-op list built from the requirements.
  function automatic void build(input int cls, input int rd, input int base,
                                input int cnt, input bit upd, input bit regoff,
                                input bit dword);
    int n;
    if (cls == 0 || cls == 1) n = (cnt == 0) ? 1 : ((cnt > MAXW) ? MAXW : cnt);
    else n = dword ? 2 : 1;
    case (cls)
      0: begin // R1 load-multiple
        for (int i = 0; i < n; i++) push(0, rd + i, i, i == n - 1, "R1");
        if (upd) push(2, base, 0, 0, "R2");
      end
      1: begin // R1 store-multiple
        for (int i = 0; i < n; i++) push(1, rd + i, i, 0, "R1");
        if (upd) push(2, base, 0, 0, "R2");
      end
      2: begin // R3 single load; R4 flag ignored here
        for (int i = 0; i < n; i++) push(0, rd + i, i, i == n - 1, "R3");
        if (upd) push(2, base, 0, 0, "R2");
      end
      3: begin
        if (regoff) push(3, base, 0, 0, "R4");
        for (int i = 0; i < n; i++) push(1, rd + i, i, 0, "R3");
        if (upd) push(2, base, 0, 0, "R2");
      end
      4: begin // R5; R2 and R4 flags have no effect
        push(4, rd & ~1, 0, 0, "R5");
        push(4, rd | 1, 1, 0, "R5");
      end
      default: push(5, rd, 0, 0, "R6");
    endcase
    q[0].first = 1;
    q[q.size()-1].last = 1;
  endfunction

  task automatic cycle();
    bit ev;
    bit in_fire, u_fire;
    if (rdy_mode == 1) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      uop_ready = lfsr[0] | lfsr[5];
    end else begin
      uop_ready = 1'b1;
    end
    #1;
    ev = (q.size() != 0);
    chk(uop_valid == ev, "R10 uop_valid", int'(uop_valid), int'(ev));
    chk(busy == ev, "R10 busy", int'(busy), int'(ev));
    chk(in_ready == !ev, "R10 in_ready", int'(in_ready), int'(!ev));
    if (prev_stall) begin
      chk(uop_op == p_op && uop_reg == p_rg && uop_idx == p_idx &&
          {uop_first, uop_last, uop_fwd} == p_fl, "R9 hold",
          int'(uop_reg), p_rg);
    end
    if (ev && uop_valid) begin
      chk(int'(uop_op) == q[0].op, {q[0].tag, " op"}, int'(uop_op), q[0].op);
      chk(int'(uop_reg) == q[0].rg, {q[0].tag, " reg"}, int'(uop_reg), q[0].rg);
      chk(int'(uop_idx) == q[0].idx, {q[0].tag, " idx"}, int'(uop_idx), q[0].idx);
      chk(int'(uop_ofs) == q[0].idx * 4, "R8 ofs", int'(uop_ofs), q[0].idx * 4);
      chk(uop_first == q[0].first, "R8 first", int'(uop_first), int'(q[0].first));
      chk(uop_last == q[0].last, "R8 last", int'(uop_last), int'(q[0].last));
      chk(uop_fwd == q[0].fwd, "R7 fwd", int'(uop_fwd), int'(q[0].fwd));
    end
    in_fire = in_valid && !ev;
    u_fire  = ev && uop_ready;
    prev_stall = ev && !uop_ready;
    p_op = int'(uop_op); p_rg = int'(uop_reg); p_idx = int'(uop_idx);
    p_fl = int'({uop_first, uop_last, uop_fwd});
    if (u_fire) void'(q.pop_front());
    if (in_fire) build(int'(in_cls), int'(in_rd), int'(in_base), int'(in_cnt),
                       in_upd, in_regoff, in_dword);
    @(negedge clk);
  endtask

  task automatic issue(input int cls, input int rd, input int base, input int cnt,
                       input bit upd, input bit regoff, input bit dword);
    bit acc;
    in_cls = 3'(cls); in_rd = REG_W'(rd); in_base = REG_W'(base);
    in_cnt = CNT_W'(cnt); in_upd = upd; in_regoff = regoff; in_dword = dword;
    in_valid = 1'b1;
    acc = 0;
    while (!acc) begin
      acc = (q.size() == 0);
      cycle();
    end
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (q.size() != 0) cycle();
    cycle();
  endtask

  task automatic scenario();
    issue(0, 4, 13, 3, 0, 0, 0);   // R1 small load-multiple
    issue(0, 2, 13, 12, 1, 1, 0);  // R1 twelve words, R2 base write, R4 ignored
    issue(1, 8, 29, 5, 1, 0, 0);   // R1 store-multiple with R2
    issue(0, 30, 1, 4, 0, 0, 0);   // R1 register wrap
    issue(0, 0, 3, 0, 0, 0, 0);    // R1 zero count
    issue(1, 1, 3, 20, 0, 0, 0);   // R1 clamp to MAX_WORDS
    issue(0, 0, 3, 16, 1, 0, 0);   // R1 full MAX_WORDS
    issue(2, 9, 7, 1, 0, 0, 0);    // R3 single load
    issue(2, 10, 7, 1, 1, 0, 1);   // R3 double load with R2
    issue(3, 11, 6, 1, 0, 0, 0);   // R3 single store
    issue(3, 12, 6, 1, 0, 1, 0);   // R4 register-offset store
    issue(3, 14, 6, 1, 1, 1, 1);   // R4 double store, R2
    issue(4, 7, 6, 1, 1, 1, 0);    // R5 odd source, R2/R4 flags ignored
    issue(4, 20, 6, 1, 0, 0, 1);   // R5 even source
    issue(5, 17, 6, 4, 1, 1, 1);   // R6 pass, flags ignored
    issue(7, 18, 6, 4, 1, 0, 0);   // R6 unused class code
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(uop_valid == 1'b0, "R11 uop_valid", int'(uop_valid), 0);
    chk(busy == 1'b0, "R11 busy", int'(busy), 0);
    chk(in_ready == 1'b1, "R11 in_ready", int'(in_ready), 1);
    rdy_mode = 0;
    scenario();
    rdy_mode = 1;
    scenario();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule